// File: doc/BRIEF.md
# Interrupt Request Delivery and End-of-Interrupt Engine

This block sits behind the redirection table of an interrupt router with many input pins. It watches the raw level of every pin and keeps one request bit per pin. It picks the next pin that may be delivered and presents a delivery message built from that pin's table entry: the pin number, the vector, the destination and the trigger type. The message stays up until a downstream agent accepts it with a ready handshake.

Edge-triggered pins latch one pending event per rising edge. A second rising edge that arrives before the first event was delivered is reported as coalesced and is dropped. A level-triggered pin is delivered once and then waits on its remote request bit until an end-of-interrupt (EOI) broadcast carries the pin's vector. If the pin is still asserted after the EOI, it is delivered again at once.

A per-pin counter tracks back-to-back re-deliveries caused by EOI. When a pin reaches the storm limit, it is parked and a shared timer runs for a programmable number of cycles. When the timer expires, every parked level pin that is still requesting is released. The table contents are inputs to this block; the path that writes the table belongs elsewhere.

Top module: `irq_deliver_engine`

## Requirements
- R1: When a pin's input goes low, its request bit clears on the next clock. A level pin that drops before its delivery is accepted withdraws the request: `dlv_valid` falls and no delivery takes place.
- R2: A rising edge on an unmasked edge pin (`cfg_level` bit 0) produces exactly one accepted delivery, however long the pin then stays high.
- R3: A rising edge on an edge pin whose previous event is still undelivered pulses that pin's `coal_pulse` bit for one cycle. The edge makes no further delivery. Level pins never pulse `coal_pulse`.
- R4: A pin whose `cfg_mask` bit is 1 is never offered for delivery. A pending edge event survives the mask and is delivered once the mask bit returns to 0.
- R5: When a delivery of a level pin (`cfg_level` bit 1) is accepted, the pin's `remote_irr` bit is 1 on the next cycle. While that bit is set, the pin is not offered again.
- R6: An EOI (`eoi_valid` with `eoi_vector`) clears `remote_irr` on every level pin whose vector equals `eoi_vector`. Pins with other vectors keep their bit.
- R7: If a level pin is still high and unmasked when its EOI is applied, it is offered again without any further pin activity.
- R8: The STORM_LIMIT-th consecutive EOI-driven re-delivery of one pin is not made. Instead the pin is parked and its counter returns to 0. After about REINJ_DELAY cycles, every parked pin that is still high, unmasked and free of remote request is delivered.
- R9: An EOI that finds a level pin low or masked resets that pin's re-delivery counter to 0.
- R10: When several pins are eligible at once, the lowest pin number is offered first.
- R11: A delivery message carries `dlv_pin` and that pin's vector, destination and trigger type from the table inputs.
- R12: An edge-configured pin always shows `remote_irr` 0.
- R13: After reset there is no delivery request, no coalesced pulse, and all `remote_irr` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | NUM_PINS | Raw interrupt pin levels |
| cfg_level | input | NUM_PINS | Trigger type per pin, 1 = level, 0 = edge |
| cfg_mask | input | NUM_PINS | Mask per pin, 1 = masked |
| cfg_vector | input | NUM_PINS*VEC_W | Vector per pin, pin i at bits [i*VEC_W +: VEC_W] |
| cfg_dest | input | NUM_PINS*DEST_W | Destination per pin, pin i at bits [i*DEST_W +: DEST_W] |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| dlv_ready | input | 1 | Downstream accepts the offered delivery |
| dlv_valid | output | 1 | A delivery is offered |
| dlv_pin | output | PIN_W | Pin being offered |
| dlv_vector | output | VEC_W | Vector of the offered pin |
| dlv_dest | output | DEST_W | Destination of the offered pin |
| dlv_level | output | 1 | Trigger type of the offered pin |
| remote_irr | output | NUM_PINS | Remote request bit per pin |
| coal_pulse | output | NUM_PINS | One-cycle coalesced-edge report per pin |

## Verification
The bench builds the engine with 8 pins, a 4-bit destination, a storm limit of 3 and a re-injection delay of 16 cycles. This lets the storm path trip after only three EOIs, and the parked period and its release fit in a few dozen cycles. Two level pins share one vector, so a single EOI touches both. With the handshake held low, several pins become pending together, which exercises the ordering and the withdrawal of a request.

// File: rtl/irq_eng_pkg.sv
package irq_eng_pkg;
  // index width for a count of items, at least one bit
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // counter width able to hold the value n
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n + 1) : 1;
  endfunction
endpackage

// File: rtl/irq_pin_slot.sv
module irq_pin_slot #(
  parameter int STORM_LIMIT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic is_level,
  input  logic masked,
  input  logic eoi_hit,
  input  logic grant_acc,
  input  logic reinject,
  output logic want,
  output logic rirr,
  output logic coal,
  output logic parked
);
  localparam int CNT_W = irq_eng_pkg::cnt_width(STORM_LIMIT);

  logic             lvl_q, lvl_d;
  logic             pend_q, pend_d;
  logic             rirr_q, rirr_d;
  logic             coal_q, coal_d;
  logic             park_q, park_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rise, park_set;

  assign rise = lvl & ~lvl_q;

  always_comb begin
    lvl_d    = lvl;
    pend_d   = 1'b0;
    coal_d   = 1'b0;
    rirr_d   = rirr_q;
    cnt_d    = cnt_q;
    park_set = 1'b0;
    if (!is_level) begin
      pend_d = rise | (pend_q & ~grant_acc);
      coal_d = rise & pend_q & ~grant_acc;
      rirr_d = 1'b0;
    end else begin
      if (grant_acc)    rirr_d = 1'b1;
      else if (eoi_hit) rirr_d = 1'b0;
      if (eoi_hit) begin
        if (!masked && lvl_q) begin
          if (cnt_q == CNT_W'(STORM_LIMIT - 1)) begin
            cnt_d    = '0;
            park_set = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else begin
          cnt_d = '0;
        end
      end
    end
    if (park_set)      park_d = 1'b1;
    else if (reinject) park_d = 1'b0;
    else               park_d = park_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
      rirr_q <= 1'b0;
      coal_q <= 1'b0;
      park_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      lvl_q  <= lvl_d;
      pend_q <= pend_d;
      rirr_q <= rirr_d;
      coal_q <= coal_d;
      park_q <= park_d;
      cnt_q  <= cnt_d;
    end
  end

  assign want   = ~masked & (is_level ? (lvl_q & ~rirr_q & ~park_q) : pend_q);
  assign rirr   = rirr_q;
  assign coal   = coal_q;
  assign parked = park_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_PINS = 24,
  localparam int PIN_W = irq_eng_pkg::idx_width(NUM_PINS)
) (
  input  logic [NUM_PINS-1:0] want,
  output logic                any,
  output logic [PIN_W-1:0]    idx
);
  always_comb begin
    idx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (want[i]) idx = PIN_W'(i);
    end
  end
  assign any = |want;
endmodule

// File: rtl/irq_storm_timer.sv
module irq_storm_timer #(
  parameter int REINJ_DELAY = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic fire
);
  localparam int DLY_W = irq_eng_pkg::cnt_width(REINJ_DELAY);

  logic             act_q, act_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;

  assign fire = act_q && (cnt_q == '0);

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (!act_q) begin
      if (arm) begin
        act_d = 1'b1;
        cnt_d = DLY_W'(REINJ_DELAY - 1);
      end
    end else if (fire) begin
      act_d = 1'b0;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/irq_deliver_engine.sv
module irq_deliver_engine #(
  parameter int NUM_PINS    = 24,
  parameter int VEC_W       = 8,
  parameter int DEST_W      = 8,
  parameter int STORM_LIMIT = 10000,
  parameter int REINJ_DELAY = 1000000,
  localparam int PIN_W = irq_eng_pkg::idx_width(NUM_PINS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        pin_level,
  input  logic [NUM_PINS-1:0]        cfg_level,
  input  logic [NUM_PINS-1:0]        cfg_mask,
  input  logic [NUM_PINS*VEC_W-1:0]  cfg_vector,
  input  logic [NUM_PINS*DEST_W-1:0] cfg_dest,
  input  logic                       eoi_valid,
  input  logic [VEC_W-1:0]           eoi_vector,
  input  logic                       dlv_ready,
  output logic                       dlv_valid,
  output logic [PIN_W-1:0]           dlv_pin,
  output logic [VEC_W-1:0]           dlv_vector,
  output logic [DEST_W-1:0]          dlv_dest,
  output logic                       dlv_level,
  output logic [NUM_PINS-1:0]        remote_irr,
  output logic [NUM_PINS-1:0]        coal_pulse
);
  logic [NUM_PINS-1:0] want, parked, grant_acc, eoi_hit;
  logic                pick_any, reinject;
  logic [PIN_W-1:0]    pick_idx;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign eoi_hit[g]   = eoi_valid && (cfg_vector[g*VEC_W +: VEC_W] == eoi_vector);
    assign grant_acc[g] = pick_any && dlv_ready && (pick_idx == PIN_W'(g));

    irq_pin_slot #(
      .STORM_LIMIT(STORM_LIMIT)
    ) slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (pin_level[g]),
      .is_level (cfg_level[g]),
      .masked   (cfg_mask[g]),
      .eoi_hit  (eoi_hit[g]),
      .grant_acc(grant_acc[g]),
      .reinject (reinject),
      .want     (want[g]),
      .rirr     (remote_irr[g]),
      .coal     (coal_pulse[g]),
      .parked   (parked[g])
    );
  end

  irq_prio_pick #(
    .NUM_PINS(NUM_PINS)
  ) pick_i (
    .want(want),
    .any (pick_any),
    .idx (pick_idx)
  );

  irq_storm_timer #(
    .REINJ_DELAY(REINJ_DELAY)
  ) timer_i (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (|parked),
    .fire (reinject)
  );

  assign dlv_valid  = pick_any;
  assign dlv_pin    = pick_idx;
  assign dlv_vector = cfg_vector[pick_idx*VEC_W +: VEC_W];
  assign dlv_dest   = cfg_dest[pick_idx*DEST_W +: DEST_W];
  assign dlv_level  = cfg_level[pick_idx];
endmodule

// File: rtl/irq_deliver_engine_chk.sv
module irq_deliver_engine_chk #(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] cfg_level,
  input logic [NUM_PINS-1:0] cfg_mask,
  input logic                dlv_ready,
  input logic                dlv_valid,
  input logic [PIN_W-1:0]    dlv_pin,
  input logic [NUM_PINS-1:0] remote_irr,
  input logic [NUM_PINS-1:0] coal_pulse
);
  assert_mask_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> !cfg_mask[dlv_pin]);

  assert_level_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && cfg_level[dlv_pin]) |-> !remote_irr[dlv_pin]);

  assert_accept_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_ready && cfg_level[dlv_pin]) |=> remote_irr[$past(dlv_pin)]);

  assert_rirr_needs_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((remote_irr & ~$past(remote_irr)) != '0) |-> $past(dlv_valid && dlv_ready));

  assert_edge_no_rirr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((remote_irr & ~$past(cfg_level)) == '0));

  assert_coal_edge_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((coal_pulse & $past(cfg_level)) == '0));
endmodule

bind irq_deliver_engine irq_deliver_engine_chk #(
  .NUM_PINS(NUM_PINS),
  .PIN_W   (PIN_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_level (cfg_level),
  .cfg_mask  (cfg_mask),
  .dlv_ready (dlv_ready),
  .dlv_valid (dlv_valid),
  .dlv_pin   (dlv_pin),
  .remote_irr(remote_irr),
  .coal_pulse(coal_pulse)
);

// File: tb/irq_deliver_engine_tb_top.sv
module irq_deliver_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 8;
  localparam int VW  = 8;
  localparam int DW  = 4;
  localparam int LIM = 3;
  localparam int DLY = 16;
  localparam int PW  = 3;

  typedef struct packed {
    logic [PW-1:0] pin;
    logic [VW-1:0] vec;
    logic [DW-1:0] dest;
    logic          lvl;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NP-1:0]    pin_level, cfg_level, cfg_mask;
  logic [NP*VW-1:0] cfg_vector;
  logic [NP*DW-1:0] cfg_dest;
  logic             eoi_valid, dlv_ready;
  logic [VW-1:0]    eoi_vector;
  logic             dlv_valid, dlv_level;
  logic [PW-1:0]    dlv_pin;
  logic [VW-1:0]    dlv_vector;
  logic [DW-1:0]    dlv_dest;
  logic [NP-1:0]    remote_irr, coal_pulse;

  int   errors = 0;
  int   checks = 0;
  int   coal_cnt [NP];
  exp_t expq [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_deliver_engine #(
    .NUM_PINS(NP), .VEC_W(VW), .DEST_W(DW),
    .STORM_LIMIT(LIM), .REINJ_DELAY(DLY)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .cfg_level(cfg_level),
    .cfg_mask(cfg_mask), .cfg_vector(cfg_vector), .cfg_dest(cfg_dest),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .dlv_ready(dlv_ready),
    .dlv_valid(dlv_valid), .dlv_pin(dlv_pin), .dlv_vector(dlv_vector),
    .dlv_dest(dlv_dest), .dlv_level(dlv_level), .remote_irr(remote_irr),
    .coal_pulse(coal_pulse)
  );

  function automatic logic [VW-1:0] vec_of(input int p);
    if (p == 2 || p == 3) return 8'h40;
    if (p == 4) return 8'h44;
    return VW'(8'h20 + p);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push_exp(input int p);
    exp_t e;
    e.pin  = PW'(p);
    e.vec  = vec_of(p);
    e.dest = DW'(p + 1);
    e.lvl  = cfg_level[p];
    expq.push_back(e);
  endtask

  task automatic send_eoi(input logic [VW-1:0] v);
    eoi_vector = v;
    eoi_valid  = 1'b1;
    step(1);
    eoi_valid  = 1'b0;
  endtask

  task automatic drained(input string req);
    check(expq.size() == 0, req, "pending expected deliveries", expq.size(), 0);
  endtask

  // monitor: pop and compare every accepted delivery
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NP; i++) coal_cnt[i] += int'(coal_pulse[i]);
      if (dlv_valid && dlv_ready) begin
        if (expq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 unexpected delivery: actual pin=%0d expected=none", dlv_pin);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(dlv_pin == e.pin, "R10", "delivered pin", dlv_pin, e.pin);
          check(dlv_vector == e.vec, "R11", "vector", dlv_vector, e.vec);
          check(dlv_dest == e.dest, "R11", "destination", dlv_dest, e.dest);
          check(dlv_level == e.lvl, "R11", "trigger type", dlv_level, e.lvl);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) coal_cnt[i] = 0;
    rst_n = 1'b0; pin_level = '0; eoi_valid = 1'b0; eoi_vector = '0; dlv_ready = 1'b1;
    cfg_level = 8'b0001_1100;
    cfg_mask  = 8'b1000_0000;
    for (int i = 0; i < NP; i++) begin
      cfg_vector[i*VW +: VW] = vec_of(i);
      cfg_dest[i*DW +: DW]   = DW'(i + 1);
    end
    step(3);
    // R13 reset state
    check(dlv_valid == 1'b0, "R13", "dlv_valid in reset", dlv_valid, 0);
    check(remote_irr == '0, "R13", "remote_irr in reset", remote_irr, 0);
    check(coal_pulse == '0, "R13", "coal_pulse in reset", coal_pulse, 0);
    rst_n = 1'b1;
    step(2);

    // R2 single edge delivery
    push_exp(0);
    pin_level[0] = 1'b1; step(4);
    pin_level[0] = 1'b0; step(3);
    drained("R2");

    // R3 / R4 coalesced edge under mask, then release
    cfg_mask[1] = 1'b1; step(1);
    pin_level[1] = 1'b1; step(2);
    pin_level[1] = 1'b0; step(2);
    pin_level[1] = 1'b1; step(3);
    check(coal_cnt[1] == 1, "R3", "coalesced pulses on pin1", coal_cnt[1], 1);
    check(dlv_valid == 1'b0, "R4", "masked pin offered", dlv_valid, 0);
    push_exp(1);
    cfg_mask[1] = 1'b0; step(4);
    drained("R4");
    pin_level[1] = 1'b0; step(2);

    // R5 level delivery sets remote request
    push_exp(2);
    pin_level[2] = 1'b1; step(4);
    check(remote_irr[2] == 1'b1, "R5", "remote_irr pin2", remote_irr[2], 1);
    step(5);
    check(dlv_valid == 1'b0, "R5", "re-offer while remote set", dlv_valid, 0);
    drained("R5");

    // R6 / R7 shared-vector EOI
    push_exp(3);
    pin_level[3] = 1'b1; step(4);
    pin_level[3] = 1'b0;
    push_exp(4);
    pin_level[4] = 1'b1; step(4);
    check(remote_irr[4] == 1'b1, "R5", "remote_irr pin4", remote_irr[4], 1);
    push_exp(2);
    send_eoi(8'h40); step(4);
    check(remote_irr[3] == 1'b0, "R6", "remote_irr pin3 after EOI", remote_irr[3], 0);
    check(remote_irr[4] == 1'b1, "R6", "remote_irr pin4 other vector", remote_irr[4], 1);
    check(remote_irr[2] == 1'b1, "R7", "pin2 re-delivered", remote_irr[2], 1);
    drained("R7");

    // R8 storm limit parks pin2 then releases it
    push_exp(2);
    send_eoi(8'h40); step(4);
    drained("R8");
    send_eoi(8'h40); step(6);
    check(remote_irr[2] == 1'b0, "R8", "pin2 parked remote_irr", remote_irr[2], 0);
    check(dlv_valid == 1'b0, "R8", "offer while parked", dlv_valid, 0);
    push_exp(2);
    step(24);
    drained("R8");
    check(remote_irr[2] == 1'b1, "R8", "pin2 released", remote_irr[2], 1);

    // R9 masked EOI clears the counter
    push_exp(2);
    send_eoi(8'h40); step(4);
    cfg_mask[2] = 1'b1; step(1);
    send_eoi(8'h40); step(4);
    check(remote_irr[2] == 1'b0, "R9", "remote_irr pin2 masked EOI", remote_irr[2], 0);
    check(dlv_valid == 1'b0, "R9", "offer while masked", dlv_valid, 0);
    push_exp(2);
    cfg_mask[2] = 1'b0; step(4);
    push_exp(2);
    send_eoi(8'h40); step(4);
    push_exp(2);
    send_eoi(8'h40); step(4);
    drained("R9");
    pin_level[2] = 1'b0; step(2);
    send_eoi(8'h40); step(3);
    pin_level[4] = 1'b0; step(2);
    send_eoi(8'h44); step(3);
    check(remote_irr[4] == 1'b0, "R6", "remote_irr pin4 after own EOI", remote_irr[4], 0);

    // R10 ascending order
    dlv_ready = 1'b0;
    pin_level[5] = 1'b1; pin_level[1] = 1'b1; pin_level[0] = 1'b1;
    step(2);
    check(dlv_valid == 1'b1 && dlv_pin == 0, "R10", "first offered pin", dlv_pin, 0);
    push_exp(0); push_exp(1); push_exp(5);
    dlv_ready = 1'b1; step(5);
    drained("R10");
    pin_level[5] = 1'b0; pin_level[1] = 1'b0; pin_level[0] = 1'b0; step(2);

    // R1 withdrawn level request
    dlv_ready = 1'b0;
    pin_level[4] = 1'b1; step(2);
    check(dlv_valid == 1'b1 && dlv_pin == 4, "R1", "pin4 offered", dlv_pin, 4);
    pin_level[4] = 1'b0; step(2);
    check(dlv_valid == 1'b0, "R1", "offer after pin low", dlv_valid, 0);
    dlv_ready = 1'b1; step(3);
    check(remote_irr[4] == 1'b0, "R1", "remote_irr pin4", remote_irr[4], 0);
    drained("R1");

    // R12 edge pins never hold a remote request
    check(remote_irr[1:0] == 2'b00 && remote_irr[5] == 1'b0, "R12",
          "edge remote_irr", int'(remote_irr), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule